// File: doc/BRIEF.md
# Shared RAM Bus Access Guard

This block stands between a system bus slave port and a word-addressed RAM that a compute engine also uses. A bus access reaches the RAM only when two conditions hold: the word address is inside the RAM depth, and the engine's busy input is low in that same cycle. Any other RAM access completes at once without a stall. A blocked read returns zero, a blocked write is dropped, and a sticky error flag records what happened. The engine always has priority, so the bus never delays it.

A small register space is selected by a separate bus select line. It holds a control word with one interrupt enable per flag, a read-only status word with the two flags, and a write-one-to-clear word. The single interrupt output is a level that stays high while any enabled flag is set.

Top module: `ram_access_guard`

## Requirements
- R1: A bus RAM access (`bus_reg`=0) with `bus_addr` < DEPTH while `eng_busy`=0 drives the RAM port in the same cycle. A write stores `bus_wdata`. A read returns the RAM word on `bus_rdata` with `bus_rvalid`=1 one cycle later.
- R2: A bus RAM access with `bus_addr` >= DEPTH sets the address-error flag (status bit 0). It does not drive the RAM. A read returns zero, and a write changes nothing.
- R3: A bus RAM access while `eng_busy`=1 sets the collision flag (status bit 1). It does not drive the RAM. A read returns zero, and a write is discarded.
- R4: An access that is both out of range and made while `eng_busy`=1 sets both flags.
- R5: `irq` is high exactly when (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1). Control is register address 0. Clearing an enable drops `irq` and leaves the flag set.
- R6: A write to register address 2 clears each flag whose bit is 1 in `bus_wdata[1:0]`. A write to the status register (address 1) has no effect.
- R7: Flags are sticky. Once set, a flag stays set until it is cleared through address 2.
- R8: After reset, both flags and both enables are 0, `irq` is 0 and `bus_rvalid` is 0.
- R9: Register reads return data one cycle later. Address 0 returns the control bits, address 1 returns the flags, and any other address returns zero. Register accesses never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 1 = register space, 0 = RAM space |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| eng_busy | input | 1 | Engine owns the RAM this cycle |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RW | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after ram_en |
| irq | output | 1 | Level interrupt |

## Verification
The RAM strobe and write enable are due in the same cycle as the bus request, so the bench checks them just before the rising edge. Flags, `irq` and read data are due one cycle after the request, so the bench checks them at the following falling edge. A behavioural reference model with its own memory array is advanced at each rising edge, so every comparison uses the value the model expects for that cycle. Dropped writes are detected by reading the same address back through the bus after the blocked cycle.

// File: rtl/ram_access_guard.sv
module ram_access_guard #(
  parameter int DEPTH = 48,
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic          bus_reg,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic          eng_busy,
  output logic          ram_en,
  output logic          ram_we,
  output logic [RW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          irq
);
  logic [1:0] flags, ctrl, set_v, clr_v;
  logic       in_range, ram_acc, reg_wr, rsel_ram;
  logic [DW-1:0] rreg_q, reg_rd;

  assign in_range = ({{(32-AW){1'b0}}, bus_addr} < DEPTH);
  assign ram_acc  = bus_valid & ~bus_reg;
  assign reg_wr   = bus_valid & bus_reg & bus_write;

  assign ram_en    = ram_acc & in_range & ~eng_busy;
  assign ram_we    = ram_en & bus_write;
  assign ram_addr  = bus_addr[RW-1:0];
  assign ram_wdata = bus_wdata;

  assign set_v = {ram_acc & eng_busy, ram_acc & ~in_range};
  assign clr_v = (reg_wr && bus_addr == AW'(2)) ? bus_wdata[1:0] : 2'b00;

  always_comb begin
    reg_rd = '0;
    if (bus_addr == AW'(0)) reg_rd[1:0] = ctrl;
    else if (bus_addr == AW'(1)) reg_rd[1:0] = flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      ctrl       <= '0;
      bus_rvalid <= 1'b0;
      rsel_ram   <= 1'b0;
      rreg_q     <= '0;
    end else begin
      flags      <= (flags & ~clr_v) | set_v;
      if (reg_wr && bus_addr == AW'(0)) ctrl <= bus_wdata[1:0];
      bus_rvalid <= bus_valid & ~bus_write;
      rsel_ram   <= ram_en & ~bus_write;
      rreg_q     <= (bus_valid && bus_reg && !bus_write) ? reg_rd : '0;
    end
  end

  assign bus_rdata = rsel_ram ? ram_rdata : rreg_q;
  assign irq = |(flags & ctrl);

  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !ram_en);
  assert_range_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> ({{(32-AW){1'b0}}, bus_addr} < DEPTH));
  assert_sticky_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && clr_v[0] == 1'b0) |=> flags[0]);
  assert_sticky_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && clr_v[1] == 1'b0) |=> flags[1]);
  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl != 2'b00));
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
endmodule

// File: tb/tb_ram_access_guard.sv
module tb_ram_access_guard;
  localparam int DEPTH = 48, AW = 8, DW = 32, RW = $clog2(DEPTH);
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_reg = 0, eng_busy = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, ram_wdata, ram_rdata;
  logic bus_rvalid, ram_en, ram_we, irq;
  logic [RW-1:0] ram_addr;
  logic [DW-1:0] mem [DEPTH];

  int tests = 0, fails = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [1:0] m_flags = 0, m_ctrl = 0;
  logic m_rvalid = 0;
  logic [DW-1:0] m_rdata = 0;

  always #2.5 clk = ~clk;

  ram_access_guard #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  always_ff @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, w, r, input int a, input logic [DW-1:0] d, input logic busy);
    logic inr, gnt;
    bus_valid = v; bus_write = w; bus_reg = r; bus_addr = AW'(a); bus_wdata = d; eng_busy = busy;
    inr = (a < DEPTH);
    gnt = v && !r && inr && !busy;
    #1;
    chk("R1/R2/R3 ram_en", {31'b0, ram_en}, {31'b0, gnt});
    chk("R1 ram_we", {31'b0, ram_we}, {31'b0, gnt && w});
    @(posedge clk);
    m_rvalid = v && !w;
    m_rdata = 0;
    if (gnt && !w) m_rdata = ref_mem[a];
    if (v && r && !w) m_rdata = (a == 0) ? {30'b0, m_ctrl} : (a == 1) ? {30'b0, m_flags} : 0;
    if (gnt && w) ref_mem[a] = d;
    if (v && r && w && a == 2) m_flags = m_flags & ~d[1:0];
    if (v && r && w && a == 0) m_ctrl = d[1:0];
    if (v && !r && !inr) m_flags[0] = 1;
    if (v && !r && busy) m_flags[1] = 1;
    @(negedge clk);
    chk("R5 irq", {31'b0, irq}, {31'b0, |(m_flags & m_ctrl)});
    chk("R1/R9 rvalid", {31'b0, bus_rvalid}, {31'b0, m_rvalid});
    if (m_rvalid) chk("R1/R2/R3/R9 rdata", bus_rdata, m_rdata);
    bus_valid = 0; eng_busy = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 0; ref_mem[i] = 0; end
    ram_rdata = 0;
    #12 @(negedge clk);
    chk("R8 irq reset", {31'b0, irq}, 0);
    chk("R8 rvalid reset", {31'b0, bus_rvalid}, 0);
    rst_n = 1;
    @(negedge clk);
    cyc(1, 0, 1, 0, 0, 0);            // R8 control reads 0
    cyc(1, 0, 1, 1, 0, 0);            // R8 status reads 0
    for (int i = 0; i < DEPTH; i += 7) cyc(1, 1, 0, i, 32'hA000 + i, 0);  // R1
    cyc(1, 1, 0, DEPTH - 1, 32'h5EED, 0);
    for (int i = 0; i < DEPTH; i += 7) cyc(1, 0, 0, i, 0, 0);
    cyc(1, 0, 0, DEPTH - 1, 0, 0);    // R1 last word
    cyc(1, 1, 1, 0, 3, 0);            // R5 enable both
    cyc(1, 0, 1, 0, 0, 0);            // R9 control readback
    cyc(1, 1, 0, DEPTH, 32'hDEAD, 0); // R2 out of range write
    cyc(1, 0, 0, DEPTH, 0, 0);        // R2 out of range read gives 0
    cyc(1, 0, 1, 1, 0, 0);            // R9 status
    cyc(1, 1, 1, 1, 0, 0);            // R6 status write ignored
    cyc(1, 0, 1, 1, 0, 0);
    cyc(1, 1, 1, 2, 1, 0);            // R6 clear addr flag
    cyc(1, 0, 1, 2, 0, 0);            // R9 clear reads 0
    cyc(1, 1, 0, 7, 32'hBAD, 1);      // R3 busy write dropped
    cyc(1, 0, 0, 7, 0, 1);            // R3 busy read zero
    cyc(1, 0, 0, 7, 0, 0);            // R3 memory unchanged
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0);  // R7 sticky
    cyc(1, 0, 1, 1, 0, 0);
    cyc(1, 1, 1, 0, 1, 0);            // R5 disable ram-err enable: irq drops
    cyc(1, 0, 1, 1, 0, 0);            // R5 flag still set
    cyc(1, 1, 1, 2, 2, 0);            // R6 clear ram flag
    cyc(1, 0, 0, 200, 0, 1);          // R4 both flags
    cyc(1, 0, 1, 1, 0, 0);
    cyc(1, 1, 1, 2, 3, 0);            // R6 clear both
    cyc(1, 0, 1, 1, 0, 0);
    cyc(1, 1, 1, 3, 3, 0);            // R9 register write elsewhere no flag
    cyc(1, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);            // engine alone: no flag
    cyc(1, 0, 1, 1, 0, 0);
    for (int i = 0; i < DEPTH; i += 7) cyc(1, 0, 0, i, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule